// File: doc/BRIEF.md
# Nine-Bit Serial Panel Command Serializer

This block sends register writes to a display controller over a three-wire serial link. The link only writes. Every word on it is nine bits long: a flag bit that tells a command byte from a data byte, followed by the byte. A host presents one transaction at a time on a valid/ready handshake. A transaction is an opcode, a payload length of zero, one or two data bytes, and a 16-bit payload. The block frames the words inside one chip-select window and drives the serial clock. It pulses `done` once the window has closed.

The serial clock follows mode 3. It rests high, data changes on its falling edge, and the panel samples on the rising edge. The serial clock period is the system clock period times the even parameter `CLK_DIV`. Between transactions chip select stays high for at least one full serial clock period. Only then is a new request accepted.

Top module: `panel_cmd_ser`

## Requirements
- R1: While reset is held and afterwards until the first request, `spi_csn`=1, `spi_sck`=1, `spi_sdo`=0, `req_ready`=1 and `done`=0.
- R2: Every word holds 9 bits, sent most significant first, one bit per serial clock period. Bit 8 (the flag) goes out first.
- R3: The flag bit is 0 for the command word and 1 for each data word. Bits 7:0 carry the byte.
- R4: `req_len`=0 sends the command word alone. `req_len`=1 sends the command and then `req_payload[7:0]`. `req_len`=2 sends the command, then `req_payload[15:8]`, then `req_payload[7:0]`. `req_len`=3 is handled as 2.
- R5: In a two-data-word transaction the high payload byte goes out before the low byte.
- R6: `spi_sck` is high whenever chip select is high. Each serial clock period is `CLK_DIV` system cycles, low for the first half and high for the second. `spi_sdo` changes only together with a falling edge of `spi_sck`, or when chip select changes.
- R7: `spi_csn` stays low without a break for the whole transaction. The first falling edge of `spi_sck` comes `CLK_DIV/2` cycles after `spi_csn` falls. `spi_csn` rises `CLK_DIV/2` cycles after the last rising edge.
- R8: After `spi_csn` rises it stays high for `CLK_DIV` cycles before `req_ready` returns.
- R9: `req_ready` is low from the cycle after acceptance until the gap of R8 ends. Changes on the request inputs while it is low have no effect on the words being sent.
- R10: `done` is high for exactly one cycle, the first cycle in which `spi_csn` is high again.
- R11: A request is taken at a clock edge where `req_valid` and `req_ready` are both high. `spi_csn` falls in the following cycle.

Top module ports are listed in order below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_opcode | input | 8 | Command byte |
| req_len | input | 2 | Number of data bytes (0, 1, 2; 3 acts as 2) |
| req_payload | input | 16 | Data bytes, high byte first when two are sent |
| spi_csn | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_sdo | output | 1 | Serial data out |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
A behavioural model in the bench predicts every output on every cycle. A separate bench receiver captures bits on rising serial clock edges and rebuilds the words. The stimulus covers all four length codes:
- Zero and one data byte tell apart which payload byte a single data word takes.
- Two bytes with distinct halves expose any swap of high and low byte.
- Length code 3 shows that it is clamped to two bytes.

Payloads with every bit set and with mixed bits expose shift and flag mistakes. Further cases are:
- A payload rewritten while a transaction is busy.
- A request held valid back to back against a busy block.

These two show that latching and the idle gap hold.

// File: rtl/panel_ser_pkg.sv
package panel_ser_pkg;
   typedef enum logic [2:0] {
      PS_IDLE,
      PS_LEAD,
      PS_LOW,
      PS_HIGH,
      PS_GAP
   } ps_state_e;
endpackage

// File: rtl/panel_ser_tick.sv
module panel_ser_tick #(
   parameter int unsigned HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic half_end
);
   localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt;

   assign half_end = (cnt == CW'(HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart || half_end)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/panel_ser_words.sv
module panel_ser_words #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned MAX_DATA = 2,
   parameter int unsigned LEN_W    = 2
) (
   input  logic [DATA_W-1:0]          opcode,
   input  logic [MAX_DATA*DATA_W-1:0] payload,
   input  logic [LEN_W-1:0]           len,
   input  logic [LEN_W-1:0]           sel,
   output logic [DATA_W:0]            word
);
   logic [DATA_W-1:0] bytes [MAX_DATA];
   logic [LEN_W-1:0]  byte_idx;
   logic [DATA_W-1:0] data_byte;

   // byte 0 is the low byte; data word k of an L-byte transfer takes byte L-k
   for (genvar g = 0; g < MAX_DATA; g++) begin : g_split
      assign bytes[g] = payload[g*DATA_W +: DATA_W];
   end

   assign byte_idx = len - sel;

   always_comb begin
      data_byte = '0;
      for (int g = 0; g < MAX_DATA; g++)
         if (byte_idx == LEN_W'(g))
            data_byte = bytes[g];
   end

   assign word = (sel == '0) ? {1'b0, opcode} : {1'b1, data_byte};
endmodule

// File: rtl/panel_ser_fsm.sv
module panel_ser_fsm
   import panel_ser_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned MAX_DATA = 2,
   parameter int unsigned LEN_W    = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   output logic                       req_ready,
   input  logic [DATA_W-1:0]          req_opcode,
   input  logic [LEN_W-1:0]           req_len,
   input  logic [MAX_DATA*DATA_W-1:0] req_payload,
   input  logic                       half_end,
   input  logic [DATA_W:0]            next_word,
   output logic                       restart,
   output logic [DATA_W-1:0]          lat_opcode,
   output logic [MAX_DATA*DATA_W-1:0] lat_payload,
   output logic [LEN_W-1:0]           lat_len,
   output logic [LEN_W-1:0]           word_sel,
   output logic                       spi_csn,
   output logic                       spi_sck,
   output logic                       spi_sdo,
   output logic                       done
);
   localparam int unsigned WORD_W = DATA_W + 1;
   localparam int unsigned BW     = $clog2(WORD_W);

   ps_state_e         state;
   logic [BW-1:0]     bit_cnt;
   logic [LEN_W-1:0]  word_cnt;
   logic [WORD_W-1:0] sh;
   logic              gap_second;
   logic              accept;
   logic [LEN_W-1:0]  len_c;

   assign accept   = req_valid && req_ready;
   assign restart  = accept;
   assign word_sel = word_cnt + 1'b1;
   assign len_c    = (req_len > LEN_W'(MAX_DATA)) ? LEN_W'(MAX_DATA) : req_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= PS_IDLE;
         req_ready   <= 1'b1;
         spi_csn     <= 1'b1;
         spi_sck     <= 1'b1;
         spi_sdo     <= 1'b0;
         done        <= 1'b0;
         bit_cnt     <= '0;
         word_cnt    <= '0;
         sh          <= '0;
         gap_second  <= 1'b0;
         lat_opcode  <= '0;
         lat_payload <= '0;
         lat_len     <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            PS_IDLE: if (accept) begin
               lat_opcode  <= req_opcode;
               lat_payload <= req_payload;
               lat_len     <= len_c;
               word_cnt    <= '0;
               bit_cnt     <= '0;
               sh          <= {1'b0, req_opcode};
               spi_sdo     <= 1'b0;
               spi_csn     <= 1'b0;
               req_ready   <= 1'b0;
               state       <= PS_LEAD;
            end
            PS_LEAD: if (half_end) begin
               spi_sck <= 1'b0;
               state   <= PS_LOW;
            end
            PS_LOW: if (half_end) begin
               spi_sck <= 1'b1;
               state   <= PS_HIGH;
            end
            PS_HIGH: if (half_end) begin
               if (bit_cnt != BW'(WORD_W - 1)) begin
                  bit_cnt <= bit_cnt + 1'b1;
                  sh      <= sh << 1;
                  spi_sdo <= sh[WORD_W-2];
                  spi_sck <= 1'b0;
                  state   <= PS_LOW;
               end else if (word_cnt != lat_len) begin
                  word_cnt <= word_cnt + 1'b1;
                  bit_cnt  <= '0;
                  sh       <= next_word;
                  spi_sdo  <= next_word[WORD_W-1];
                  spi_sck  <= 1'b0;
                  state    <= PS_LOW;
               end else begin
                  spi_csn    <= 1'b1;
                  spi_sdo    <= 1'b0;
                  done       <= 1'b1;
                  gap_second <= 1'b0;
                  state      <= PS_GAP;
               end
            end
            PS_GAP: if (half_end) begin
               if (gap_second) begin
                  req_ready <= 1'b1;
                  state     <= PS_IDLE;
               end else begin
                  gap_second <= 1'b1;
               end
            end
            default: state <= PS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/panel_cmd_ser.sv
module panel_cmd_ser #(
   parameter int unsigned CLK_DIV  = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned MAX_DATA = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                req_valid,
   output logic                                req_ready,
   input  logic [DATA_W-1:0]                   req_opcode,
   input  logic [$clog2(MAX_DATA+2)-1:0]       req_len,
   input  logic [MAX_DATA*DATA_W-1:0]          req_payload,
   output logic                                spi_csn,
   output logic                                spi_sck,
   output logic                                spi_sdo,
   output logic                                done
);
   localparam int unsigned HALF  = CLK_DIV / 2;
   localparam int unsigned LEN_W = $clog2(MAX_DATA + 2);

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("CLK_DIV must be even and at least 2");
   end
   if (MAX_DATA < 1 || DATA_W < 1) begin : g_bad_shape
      $error("DATA_W and MAX_DATA must be at least 1");
   end

   logic                       half_end;
   logic                       restart;
   logic [DATA_W-1:0]          lat_opcode;
   logic [MAX_DATA*DATA_W-1:0] lat_payload;
   logic [LEN_W-1:0]           lat_len;
   logic [LEN_W-1:0]           word_sel;
   logic [DATA_W:0]            next_word;

   panel_ser_tick #(.HALF(HALF)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .half_end (half_end)
   );

   panel_ser_words #(.DATA_W(DATA_W), .MAX_DATA(MAX_DATA), .LEN_W(LEN_W)) u_words (
      .opcode  (lat_opcode),
      .payload (lat_payload),
      .len     (lat_len),
      .sel     (word_sel),
      .word    (next_word)
   );

   panel_ser_fsm #(.DATA_W(DATA_W), .MAX_DATA(MAX_DATA), .LEN_W(LEN_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_opcode  (req_opcode),
      .req_len     (req_len),
      .req_payload (req_payload),
      .half_end    (half_end),
      .next_word   (next_word),
      .restart     (restart),
      .lat_opcode  (lat_opcode),
      .lat_payload (lat_payload),
      .lat_len     (lat_len),
      .word_sel    (word_sel),
      .spi_csn     (spi_csn),
      .spi_sck     (spi_sck),
      .spi_sdo     (spi_sdo),
      .done        (done)
   );
endmodule

// File: rtl/panel_cmd_ser_chk.sv
module panel_cmd_ser_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic spi_csn,
   input logic spi_sck,
   input logic spi_sdo,
   input logic done
);
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_done_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $rose(spi_csn));

   a_r10_cs_rise_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_csn) |-> done);

   a_r6_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      spi_csn |-> spi_sck);

   a_r6_sdo_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_csn && $past(!spi_csn) && !$fell(spi_sck)) |-> $stable(spi_sdo));

   a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_csn |-> !req_ready);

   a_r11_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!spi_csn && !req_ready));
endmodule

bind panel_cmd_ser panel_cmd_ser_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .spi_csn   (spi_csn),
   .spi_sck   (spi_sck),
   .spi_sdo   (spi_sdo),
   .done      (done)
);

// File: tb/panel_cmd_ser_bench.sv
`timescale 1ns/1ps
module panel_cmd_ser_bench;
   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_opcode = '0;
   logic [1:0]  req_len = '0;
   logic [15:0] req_payload = '0;
   logic        req_ready, spi_csn, spi_sck, spi_sdo, done;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   panel_cmd_ser #(.CLK_DIV(DIV)) u_panel_cmd_ser (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_opcode(req_opcode), .req_len(req_len), .req_payload(req_payload),
      .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_sdo(spi_sdo), .done(done));

   task automatic chk(string tag, logic act, logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
      end
   endtask

   // reference model
   bit         m_busy = 0;
   int         m_t = 0;
   int         m_end = 0;
   bit         m_bits[$];
   logic [8:0] exp_words[$];
   int         exp_counts[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0;
      end else if (m_busy) begin
         m_t++;
         if (m_t == m_end + DIV) m_busy = 0;
      end else if (req_valid) begin
         automatic int le = (req_len > 2) ? 2 : int'(req_len);
         automatic logic [8:0] w;
         m_bits.delete();
         for (int k = 0; k <= le; k++) begin
            if (k == 0) w = {1'b0, req_opcode};
            else        w = {1'b1, req_payload[8*(le-k) +: 8]};
            exp_words.push_back(w);
            for (int b = 8; b >= 0; b--) m_bits.push_back(w[b]);
         end
         exp_counts.push_back(le + 1);
         m_busy = 1;
         m_t    = 0;
         m_end  = HALF + 2 * HALF * m_bits.size();
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         chk("R1 csn in reset", spi_csn, 1'b1);
         chk("R1 sck in reset", spi_sck, 1'b1);
         chk("R1 sdo in reset", spi_sdo, 1'b0);
         chk("R1 ready in reset", req_ready, 1'b1);
         chk("R1 done in reset", done, 1'b0);
      end else if (!m_busy) begin
         chk("R1 csn idle", spi_csn, 1'b1);
         chk("R6 sck idle", spi_sck, 1'b1);
         chk("R2 sdo idle", spi_sdo, 1'b0);
         chk("R9 ready idle", req_ready, 1'b1);
         chk("R10 done idle", done, 1'b0);
      end else if (m_t < HALF) begin
         chk("R11 csn lead", spi_csn, 1'b0);
         chk("R7 sck lead", spi_sck, 1'b1);
         chk("R2 sdo lead", spi_sdo, m_bits[0]);
         chk("R9 ready lead", req_ready, 1'b0);
         chk("R10 done lead", done, 1'b0);
      end else if (m_t < m_end) begin
         automatic int j  = (m_t - HALF) / (2 * HALF);
         automatic int ph = ((m_t - HALF) / HALF) % 2;
         chk("R7 csn frame", spi_csn, 1'b0);
         chk("R6 sck phase", spi_sck, ph[0]);
         chk("R2 sdo bit", spi_sdo, m_bits[j]);
         chk("R9 ready busy", req_ready, 1'b0);
         chk("R10 done busy", done, 1'b0);
      end else begin
         chk("R8 csn gap", spi_csn, 1'b1);
         chk("R6 sck gap", spi_sck, 1'b1);
         chk("R2 sdo gap", spi_sdo, 1'b0);
         chk("R8 ready gap", req_ready, 1'b0);
         chk("R10 done pulse", done, (m_t == m_end));
      end
   end

   // independent receiver: sample on rising serial clock inside the frame
   bit         in_frame = 0;
   int         rx_n = 0;
   logic [8:0] rx_sh = '0;
   logic [8:0] rx_words[$];

   always @(negedge spi_csn) begin
      in_frame = 1; rx_n = 0; rx_words.delete();
   end

   always @(posedge spi_sck) if (in_frame && !spi_csn) begin
      rx_sh = {rx_sh[7:0], spi_sdo};
      rx_n++;
      if (rx_n % 9 == 0) rx_words.push_back(rx_sh);
   end

   always @(posedge spi_csn) if (in_frame) begin
      automatic int n = (exp_counts.size() > 0) ? exp_counts.pop_front() : -1;
      in_frame = 0;
      tests++;
      if (rx_n != 9 * n) begin
         fails++;
         $display("FAIL R2/R4 bit count: actual %0d expected %0d", rx_n, 9 * n);
      end
      for (int k = 0; k < rx_words.size(); k++) begin
         automatic logic [8:0] e = (exp_words.size() > 0) ? exp_words.pop_front() : 9'h1ff;
         tests++;
         if (rx_words[k] !== e) begin
            fails++;
            $display("FAIL R3/R5 word %0d: actual %h expected %h", k, rx_words[k], e);
         end
      end
   end

   task automatic send(logic [7:0] op, logic [1:0] len, logic [15:0] pl);
      @(negedge clk);
      req_valid = 1'b1; req_opcode = op; req_len = len; req_payload = pl;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (2) @(posedge clk);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      send(8'h11, 2'd0, 16'h0000);          // R4 command alone
      wait_idle();
      send(8'hB0, 2'd1, 16'hAA17);          // R4 one byte takes low half
      wait_idle();
      send(8'hB8, 2'd2, 16'hFFF9);          // R5 high byte first
      wait_idle();
      send(8'hC3, 2'd2, 16'h2040);          // R5 distinct halves
      wait_idle();
      send(8'h5A, 2'd3, 16'h60C0);          // R4 length 3 acts as 2
      // R9 payload rewritten while busy must not alter the words
      req_payload = 16'h1234; req_opcode = 8'h00; req_len = 2'd0;
      wait_idle();
      send(8'h29, 2'd1, 16'h00FF);          // R11 back-to-back held valid
      send(8'hFF, 2'd2, 16'h0102);
      send(8'h00, 2'd0, 16'hFFFF);
      wait_idle();
      repeat (10) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule